// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a two-wire SMBus target that lets a host controller read and write a small bank of 8-bit configuration registers. The bank contents also appear on a parallel bus, so downstream control logic sees every committed value straight away. SCL and SDA are brought in as plain inputs and resynchronised to a fast system clock. The block pulls SDA low through a single output-enable, which drives an external open-drain pad.

After the address byte, the host sends a command byte. If its top bit is set, the access is indexed: the low seven bits give the starting register, and one data byte (byte access) or two data bytes (word access, low byte first) follow. If its top bit is clear, the access is a block access. A block write carries a byte count ahead of its data. A block read, entered through a repeated start with the read address, returns the bank size first and then the registers from index 0 upward. Every transfer auto-increments its register pointer.

Top module: `smbus_cfg_slave`

## Requirements
- R1: The slave ACKs only the 7-bit address 7'h69, which is the byte 0xD2 for a write and 0xD3 for a read. For any other address it does not ACK, and it keeps SDA released through every following byte until the next start.
- R2: A command byte with bit 7 = 1 sets the register pointer to bits 6:0. A following data byte is stored at that offset, and a read after a repeated start returns the register at that offset.
- R3: A word write stores the first data byte at the offset and the second at the offset plus one. A word read returns the register at the offset, then the register at the offset plus one.
- R4: A command byte with bit 7 = 0 starts a block write. The next byte is a count N, and the data bytes after it go to registers 0, 1, 2 and upward. Data bytes beyond N, or beyond the 8th register, are ACKed but not stored.
- R5: In a block read (command 0x00, repeated start, 0xD3), the first byte returned is the bank size 8, followed by registers 0 to 7 in order.
- R6: An offset of 8 or more reads back as 0x00. A write to such an offset is ACKed and leaves all registers unchanged.
- R7: The slave ACKs every command, count and data byte of a write whose address matched.
- R8: A start or stop that arrives before a byte and its ACK have completed aborts the transfer. The partial byte is not stored, bytes already ACKed stay stored, and the slave accepts the next transfer normally.
- R9: The SDA output enable changes only while the synchronised SCL is low.
- R10: After reset all registers read 0x00 and SDA is released.
- R11: When the host NACKs a byte the slave sent, the slave releases SDA and does not drive it again until the next start, even if SCL keeps toggling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| regs_o | output | NREG*8 | Register bank; register i occupies bits 8*i+7 down to 8*i |

## Verification
The bench targets the places where the pointer and the count interact. A block write longer than its count must stop storing exactly at the count. A ten-byte block must not wrap into register 0. A word read that starts at the last register must return 0x00 for its second byte. A design that got these wrong would corrupt low registers or return stale data. The bench also aborts transfers mid-byte, both with a stop and with a repeated start. A slave that stored data on the eighth bit, rather than after the ACK, would keep the partial byte. It also checks that the slave leaves SDA alone after a wrong address and after a host NACK. A slave that still acknowledged or drove data at those points would corrupt the bus for other targets.

// File: rtl/smbus_cfg_pkg.sv
package smbus_cfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_SKIP
  } bus_state_e;

  typedef enum logic [1:0] {
    PH_ADDR, PH_CMD, PH_COUNT, PH_DATA
  } rx_phase_e;

  typedef struct packed {
    logic rise;
    logic fall;
    logic start;
    logic stop;
    logic sda;
  } line_ev_t;
endpackage

// File: rtl/smbus_line_sync.sv
module smbus_line_sync
  import smbus_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     scl_i,
  input  logic     sda_i,
  output logic     scl_o,
  output line_ev_t ev_o
);
  // index SYNC_STAGES-1 is the synchronised value, index SYNC_STAGES the previous one
  logic [SYNC_STAGES:0] scl_sh, sda_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-1:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-1:0], sda_i};
    end
  end

  logic scl_s, scl_p, sda_s, sda_p;
  assign scl_s = scl_sh[SYNC_STAGES-1];
  assign scl_p = scl_sh[SYNC_STAGES];
  assign sda_s = sda_sh[SYNC_STAGES-1];
  assign sda_p = sda_sh[SYNC_STAGES];

  assign scl_o      = scl_s;
  assign ev_o.rise  = scl_s & ~scl_p;
  assign ev_o.fall  = ~scl_s & scl_p;
  assign ev_o.start = scl_s & scl_p & sda_p & ~sda_s;
  assign ev_o.stop  = scl_s & scl_p & ~sda_p & sda_s;
  assign ev_o.sda   = sda_s;
endmodule

// File: rtl/smbus_reg_bank.sv
module smbus_reg_bank #(
  parameter int NREG = 8,
  parameter int AW   = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [7:0]      wr_data_i,
  input  logic [AW-1:0]   rd_addr_i,
  output logic [7:0]      rd_data_o,
  output logic [NREG*8-1:0] regs_o
);
  logic [7:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   regs_q[g] <= 8'h00;
      else if (wr_en_i && wr_addr_i == AW'(g))       regs_q[g] <= wr_data_i;
    end
    assign regs_o[8*g +: 8] = regs_q[g];
  end

  always_comb begin
    rd_data_o = 8'h00;
    for (int i = 0; i < NREG; i++)
      if (rd_addr_i == AW'(i)) rd_data_o = regs_q[i];
  end
endmodule

// File: rtl/smbus_proto_fsm.sv
module smbus_proto_fsm
  import smbus_cfg_pkg::*;
#(
  parameter int         NREG  = 8,
  parameter logic [6:0] ADDR7 = 7'h69,
  parameter int         PW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  line_ev_t      ev_i,
  input  logic [7:0]    rd_data_i,
  output logic          sda_oe_o,
  output logic          wr_en_o,
  output logic [PW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic [PW-1:0] rd_addr_o
);
  localparam logic [7:0]    SIZE_BYTE = 8'(NREG);
  localparam logic [PW-1:0] SIZE_PTR  = PW'(NREG);

  bus_state_e    state_q;
  rx_phase_e     phase_q;
  logic [3:0]    bit_cnt_q;
  logic [7:0]    sh_q, tx_q, left_q, wr_data_q;
  logic [PW-1:0] ptr_q, wr_addr_q;
  logic          blk_q, cnt_pend_q, rd_mode_q, host_ack_q, oe_q, wr_en_q;

  logic          byte_done, in_range;
  logic [PW-1:0] ptr_inc;
  logic [7:0]    tx_next;

  assign byte_done = (bit_cnt_q == 4'd8);
  assign in_range  = (ptr_q < SIZE_PTR);
  assign ptr_inc   = (ptr_q == '1) ? ptr_q : ptr_q + 1'b1;
  assign rd_addr_o = ptr_q;
  assign tx_next   = cnt_pend_q ? SIZE_BYTE : rd_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      phase_q    <= PH_ADDR;
      bit_cnt_q  <= '0;
      sh_q       <= '0;
      tx_q       <= '0;
      left_q     <= '0;
      wr_data_q  <= '0;
      ptr_q      <= '0;
      wr_addr_q  <= '0;
      blk_q      <= 1'b0;
      cnt_pend_q <= 1'b0;
      rd_mode_q  <= 1'b0;
      host_ack_q <= 1'b0;
      oe_q       <= 1'b0;
      wr_en_q    <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      if (ev_i.start) begin
        state_q   <= ST_RX;
        phase_q   <= PH_ADDR;
        bit_cnt_q <= '0;
        oe_q      <= 1'b0;
      end else if (ev_i.stop) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_RX: begin
            if (ev_i.rise && !byte_done) begin
              sh_q      <= {sh_q[6:0], ev_i.sda};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (ev_i.fall && byte_done) begin
              if (phase_q == PH_ADDR && sh_q[7:1] != ADDR7) begin
                state_q <= ST_SKIP;
              end else begin
                if (phase_q == PH_ADDR) rd_mode_q <= sh_q[0];
                oe_q    <= 1'b1;
                state_q <= ST_RX_ACK;
              end
            end
          end
          ST_RX_ACK: begin
            if (ev_i.fall) begin
              oe_q      <= 1'b0;
              bit_cnt_q <= '0;
              state_q   <= ST_RX;
              unique case (phase_q)
                PH_ADDR: begin
                  if (rd_mode_q) begin
                    state_q <= ST_TX;
                    tx_q    <= tx_next;
                    oe_q    <= ~tx_next[7];
                    if (cnt_pend_q) cnt_pend_q <= 1'b0;
                    else            ptr_q      <= ptr_inc;
                  end else begin
                    phase_q <= PH_CMD;
                  end
                end
                PH_CMD: begin
                  blk_q <= ~sh_q[7];
                  if (sh_q[7]) begin
                    ptr_q      <= {{(PW-7){1'b0}}, sh_q[6:0]};
                    cnt_pend_q <= 1'b0;
                    phase_q    <= PH_DATA;
                  end else begin
                    ptr_q      <= '0;
                    cnt_pend_q <= 1'b1;
                    phase_q    <= PH_COUNT;
                  end
                end
                PH_COUNT: begin
                  left_q     <= sh_q;
                  cnt_pend_q <= 1'b0;
                  phase_q    <= PH_DATA;
                end
                default: begin
                  if (in_range && (!blk_q || left_q != 8'd0)) begin
                    wr_en_q   <= 1'b1;
                    wr_addr_q <= ptr_q;
                    wr_data_q <= sh_q;
                  end
                  if (blk_q && left_q != 8'd0) left_q <= left_q - 8'd1;
                  ptr_q <= ptr_inc;
                end
              endcase
            end
          end
          ST_TX: begin
            if (ev_i.rise && !byte_done) begin
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (ev_i.fall) begin
              if (byte_done) begin
                oe_q    <= 1'b0;
                state_q <= ST_TX_ACK;
              end else begin
                oe_q <= ~tx_q[6];
                tx_q <= {tx_q[6:0], 1'b0};
              end
            end
          end
          ST_TX_ACK: begin
            if (ev_i.rise) begin
              host_ack_q <= ~ev_i.sda;
            end else if (ev_i.fall) begin
              bit_cnt_q <= '0;
              if (host_ack_q) begin
                state_q <= ST_TX;
                tx_q    <= tx_next;
                oe_q    <= ~tx_next[7];
                if (cnt_pend_q) cnt_pend_q <= 1'b0;
                else            ptr_q      <= ptr_inc;
              end else begin
                state_q <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
endmodule

// File: rtl/smbus_cfg_slave.sv
module smbus_cfg_slave
  import smbus_cfg_pkg::*;
#(
  parameter int         NREG        = 8,
  parameter logic [6:0] ADDR7       = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [NREG*8-1:0] regs_o
);
  localparam int PW = 8;

  line_ev_t      line_ev;
  logic          scl_sync, start_det, stop_det;
  logic          wr_en;
  logic [PW-1:0] wr_addr, rd_addr;
  logic [7:0]    wr_data, rd_data;

  smbus_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .scl_o (scl_sync),
    .ev_o  (line_ev)
  );

  assign start_det = line_ev.start;
  assign stop_det  = line_ev.stop;

  smbus_proto_fsm #(.NREG(NREG), .ADDR7(ADDR7), .PW(PW)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (line_ev),
    .rd_data_i(rd_data),
    .sda_oe_o (sda_oe_o),
    .wr_en_o  (wr_en),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data),
    .rd_addr_o(rd_addr)
  );

  smbus_reg_bank #(.NREG(NREG), .AW(PW)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data),
    .regs_o   (regs_o)
  );
endmodule

// File: rtl/smbus_cfg_checker.sv
module smbus_cfg_checker #(
  parameter int NREG = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_s,
  input logic              start_det,
  input logic              stop_det,
  input logic              sda_oe,
  input logic              wr_en,
  input logic [7:0]        wr_addr,
  input logic [NREG*8-1:0] regs
);
  assert_oe_scl_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

  assert_start_release_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_oe);

  assert_stop_release_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe);

  assert_wr_in_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (wr_addr < 8'(NREG)));

  assert_regs_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en) |-> $stable(regs));

  assert_commit_scl_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> !scl_s);
endmodule

bind smbus_cfg_slave smbus_cfg_checker #(.NREG(NREG)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_s    (scl_sync),
  .start_det(start_det),
  .stop_det (stop_det),
  .sda_oe   (sda_oe_o),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .regs     (regs_o)
);

// File: tb/smbus_cfg_slave_test.sv
module smbus_cfg_slave_test;
  localparam int NREG = 8;
  localparam int Q    = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] regs;
  logic sda_bus;

  assign sda_bus = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  smbus_cfg_slave #(.NREG(NREG)) uut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .scl_i   (scl_m),
    .sda_i   (sda_bus),
    .sda_oe_o(sda_oe),
    .regs_o  (regs)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int r9_bad   = 0;
  logic prev_oe = 1'b0;
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_oe !== prev_oe && scl_m) r9_bad++;
      prev_oe = sda_oe;
    end
  end

  function automatic logic [7:0] reg_at(input int i);
    return regs[8*i +: 8];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
    wait_q();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wait_q();
    scl_m = 1'b1; wait_q(); wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    ack = ~sda_bus; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic get_byte(input logic nack, output logic [7:0] d);
    d = 8'h00;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; wait_q();
      scl_m = 1'b1; wait_q();
      d = {d[6:0], sda_bus}; wait_q();
      scl_m = 1'b0; wait_q();
    end
    put_bit(nack);
  endtask

  task automatic do_write(input logic [7:0] cmd, input int n, output logic ok);
    logic a;
    bus_start();
    put_byte(8'hD2, a); ok = a;
    put_byte(cmd, a);   ok &= a;
    for (int i = 0; i < n; i++) begin
      put_byte(wbuf[i], a); ok &= a;
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [7:0] cmd, input int n, output logic ok);
    logic a;
    bus_start();
    put_byte(8'hD2, a); ok = a;
    put_byte(cmd, a);   ok &= a;
    bus_start();
    put_byte(8'hD3, a); ok &= a;
    for (int i = 0; i < n; i++) get_byte(i == n - 1, rbuf[i]);
    bus_stop();
  endtask

  task automatic t_reset();
    check("R10 regs", 64'(regs), 64'h0);
    check("R10 sda_oe", 64'(sda_oe), 64'h0);
  endtask

  task automatic t_addr_mismatch();
    logic a;
    bus_start();
    put_byte(8'hA4, a); check("R1 wrong addr nack", 64'(a), 64'h0);
    put_byte(8'h83, a); check("R1 released after mismatch", 64'(a), 64'h0);
    put_byte(8'h77, a); check("R1 released after mismatch", 64'(a), 64'h0);
    bus_stop();
    check("R1 regs untouched", 64'(regs), 64'h0);
  endtask

  task automatic t_byte();
    logic ok;
    wbuf[0] = 8'h5A;
    do_write(8'h83, 1, ok);
    check("R7 byte write acked", 64'(ok), 64'h1);
    check("R2 byte write offset 3", 64'(reg_at(3)), 64'h5A);
    do_read(8'h83, 1, ok);
    check("R1 read addr acked", 64'(ok), 64'h1);
    check("R2 byte read offset 3", 64'(rbuf[0]), 64'h5A);
  endtask

  task automatic t_word();
    logic ok;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    do_write(8'h85, 2, ok);
    check("R7 word write acked", 64'(ok), 64'h1);
    check("R3 word low", 64'(reg_at(5)), 64'h11);
    check("R3 word high", 64'(reg_at(6)), 64'h22);
    do_read(8'h85, 2, ok);
    check("R3 word read low", 64'(rbuf[0]), 64'h11);
    check("R3 word read high", 64'(rbuf[1]), 64'h22);
  endtask

  task automatic t_block_write();
    logic ok;
    wbuf[0] = 8'd3;
    for (int i = 0; i < 4; i++) wbuf[i+1] = 8'hA0 + 8'(i);
    do_write(8'h00, 5, ok);
    check("R4 excess byte acked", 64'(ok), 64'h1);
    check("R4 block count 3", 64'(regs), 64'h0022_1100_5AA2_A1A0);
    wbuf[0] = 8'd10;
    for (int i = 0; i < 10; i++) wbuf[i+1] = 8'h30 + 8'(i);
    do_write(8'h00, 11, ok);
    check("R4 bytes past bank acked", 64'(ok), 64'h1);
    check("R4 block no wrap", 64'(regs), 64'h3736_3534_3332_3130);
  endtask

  task automatic t_block_read();
    logic ok;
    do_read(8'h00, 9, ok);
    check("R5 count byte", 64'(rbuf[0]), 64'h8);
    for (int i = 0; i < 8; i++)
      check("R5 block data", 64'(rbuf[i+1]), 64'(8'h30 + 8'(i)));
  endtask

  task automatic t_out_of_range();
    logic ok;
    wbuf[0] = 8'hFF;
    do_write(8'hC0, 1, ok);
    check("R6 far write acked", 64'(ok), 64'h1);
    check("R6 far write ignored", 64'(regs), 64'h3736_3534_3332_3130);
    do_read(8'hC0, 1, ok);
    check("R6 far read zero", 64'(rbuf[0]), 64'h0);
    do_read(8'h87, 2, ok);
    check("R6 last reg", 64'(rbuf[0]), 64'h37);
    check("R6 past end zero", 64'(rbuf[1]), 64'h0);
  endtask

  task automatic t_abort();
    logic a, ok;
    bus_start();
    put_byte(8'hD2, a); put_byte(8'h82, a); put_byte(8'hC3, a);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_stop();
    check("R8 acked byte kept", 64'(reg_at(2)), 64'hC3);
    check("R8 partial byte dropped on stop", 64'(reg_at(3)), 64'h33);
    bus_start();
    put_byte(8'hD2, a); put_byte(8'h81, a);
    for (int i = 0; i < 5; i++) put_bit(1'b0);
    bus_start();
    bus_stop();
    check("R8 partial byte dropped on start", 64'(reg_at(1)), 64'h31);
    do_read(8'h81, 1, ok);
    check("R8 recovers after abort", 64'(rbuf[0]), 64'h31);
  endtask

  task automatic t_nack_release();
    logic a;
    logic [7:0] d;
    bus_start();
    put_byte(8'hD2, a); put_byte(8'h80, a);
    bus_start();
    put_byte(8'hD3, a);
    get_byte(1'b1, d);
    check("R11 byte before nack", 64'(d), 64'h30);
    get_byte(1'b1, d);
    check("R11 released after nack", 64'(d), 64'hFF);
    bus_stop();
  endtask

  initial begin
    repeat (20) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset();
    t_addr_mismatch();
    t_byte();
    t_word();
    t_block_write();
    t_block_read();
    t_out_of_range();
    t_abort();
    t_nack_release();
    check("R9 oe changes only with scl low", 64'(r9_bad), 64'h0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule